// File: doc/BRIEF.md
# Serial Link Power-State Controller

This block sequences the low-power states of a serial-link receiver. Software arms sleep by writing 1 to a sleep control bit. The controller then turns the receiver core off as soon as the serial link goes quiet, or when a fixed timeout runs out, whichever comes first. Two events can wake a sleeping core:

- A command on the control channel starts a temporary wake. Software makes it permanent by writing 0 to the sleep bit. If software does not do so before the timeout runs out again, the core goes back to sleep.
- Activity on the serial link starts a remote wake. The controller clears the sleep bit by itself once the link reports lock.

An active-low power-down pin overrides all sleep behaviour. It tristates the outputs, holds the configuration registers in reset and keeps the core off. When the pin is released, the controller first releases the register reset. One cycle later it pulses a strobe that captures the strap-pin levels. All intervals come from a cycle counter scaled by a cycles-per-millisecond parameter, so simulation can shorten them.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is 5 (power-down) with `out_hiz`=1, `reg_rst`=1, `core_pwr_en`=0 and `sleep_bit`=0. With `pwdn_n` high, the power-up sequence of R9 then runs and ends in state 0.
- R2: In state 0 (active), a write of 1 (`sleep_wr`=1, `sleep_wdata`=1) sets `sleep_bit` and moves to state 1 (armed) at the same edge. A write of 0 in state 1 clears `sleep_bit` and returns to state 0 at that edge.
- R3: State 1 moves to state 2 (asleep) at the first edge where `link_active` is sampled low, or at the T_SLP-th edge spent in state 1, whichever comes first. T_SLP = SLEEP_MS*CYC_PER_MS. In state 2, `core_pwr_en`=0.
- R4: In state 2, `cc_cmd` moves to state 3 (temporary wake) at the next edge with `core_pwr_en`=1 and `sleep_bit` still 1. `wake_rdy` is 1 once T_WAKE = WAKE_MS*CYC_PER_MS edges have passed in state 3.
- R5: In state 3, a write of 0 clears `sleep_bit` and moves to state 0 at that edge. Without that write, the block returns to state 2 at the T_SLP-th edge in state 3, with `sleep_bit` still 1.
- R6: In state 2 with no `cc_cmd`, high `link_active` moves to state 4 (remote wake) with `core_pwr_en`=1. In state 4, `link_lock` moves to state 0 and clears `sleep_bit`. Low `link_active` without lock moves back to state 2.
- R7: In state 2, writes to the sleep bit are ignored: `sleep_bit` and `pwr_state` are unchanged.
- R8: `pwdn_n` passes through a two-flop synchronizer. Its low level forces state 5 at the third rising edge after it is driven, from any state. In state 5, `out_hiz`=1, `reg_rst`=1, `core_pwr_en`=0 and `sleep_bit`=0, and writes and `cc_cmd` have no effect.
- R9: After `pwdn_n` goes high, the third edge enters state 6 (`reg_rst`=0). The next edge enters state 7, where `strap_lat` is 1 for that one cycle. The following edge enters state 0 and loads `strap_q` with `strap_in`.
- R10: `pwr_state` encodes 0 active, 1 armed, 2 asleep, 3 temporary wake, 4 remote wake, 5 power-down, 6 reset release, 7 strap latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn_n | input | 1 | Asynchronous power-down pin, active low |
| sleep_wr | input | 1 | Write strobe for the sleep control bit |
| sleep_wdata | input | 1 | Value written to the sleep bit |
| cc_cmd | input | 1 | Control-channel command strobe |
| link_active | input | 1 | Serial link activity detected |
| link_lock | input | 1 | Serial link locked |
| strap_in | input | STRAP_W | Strap pin levels |
| sleep_bit | output | 1 | Current sleep control bit |
| core_pwr_en | output | 1 | Receiver core power enable |
| out_hiz | output | 1 | Output tristate enable |
| reg_rst | output | 1 | Configuration register reset |
| strap_lat | output | 1 | One-cycle strap capture strobe |
| strap_q | output | STRAP_W | Captured strap levels |
| wake_rdy | output | 1 | Temporary wake has lasted T_WAKE cycles |
| pwr_state | output | 3 | Power state code |

## Verification
Writes, `cc_cmd`, activity and lock all take effect at the first rising edge after they are driven. The power-down pin takes effect only at the third edge, because of its synchronizer. The strap strobe follows the reset release by exactly one edge, and the strap value follows one edge after that. The bench drives inputs just after a falling edge and samples after each following falling edge, counting edges from the stimulus. It sweeps the link-drop cycle across the whole armed window and the confirming write across the whole temporary-wake window. This lets it compare the exact edge of each transition, and each cycle of `wake_rdy`, against arithmetic on T_SLP and T_WAKE.

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int CYC_PER_MS = 1000,
  parameter int SLEEP_MS   = 8,
  parameter int WAKE_MS    = 5,
  parameter int STRAP_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwdn_n,
  input  logic               sleep_wr,
  input  logic               sleep_wdata,
  input  logic               cc_cmd,
  input  logic               link_active,
  input  logic               link_lock,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               sleep_bit,
  output logic               core_pwr_en,
  output logic               out_hiz,
  output logic               reg_rst,
  output logic               strap_lat,
  output logic [STRAP_W-1:0] strap_q,
  output logic               wake_rdy,
  output logic [2:0]         pwr_state
);

  localparam int T_SLP  = SLEEP_MS * CYC_PER_MS;
  localparam int T_WAKE = WAKE_MS * CYC_PER_MS;
  localparam int CW     = $clog2(T_SLP + 1);

  typedef enum logic [2:0] {
    ST_ACT = 3'd0, ST_ARM = 3'd1, ST_SLP = 3'd2, ST_WTMP = 3'd3,
    ST_RWK = 3'd4, ST_PD  = 3'd5, ST_REL = 3'd6, ST_LAT  = 3'd7
  } st_t;

  st_t          state, state_nx;
  logic [1:0]   pd_sync;
  logic [CW-1:0] cnt;
  logic         sleep_q, sleep_nx;

  wire pd    = ~pd_sync[1];
  wire tmo   = (cnt == CW'(T_SLP - 1));
  wire wr_ok = sleep_wr && (state inside {ST_ACT, ST_ARM, ST_WTMP, ST_RWK});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pd_sync <= 2'b00;
    else        pd_sync <= {pd_sync[0], pwdn_n};

  always_comb begin
    sleep_nx = sleep_q;
    if (wr_ok) sleep_nx = sleep_wdata;
    if (state == ST_RWK && link_lock) sleep_nx = 1'b0;
    if (pd || state == ST_PD) sleep_nx = 1'b0;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_ACT:  if (sleep_nx) state_nx = ST_ARM;
      ST_ARM:  if (!sleep_nx) state_nx = ST_ACT;
               else if (!link_active || tmo) state_nx = ST_SLP;
      ST_SLP:  if (cc_cmd) state_nx = ST_WTMP;
               else if (link_active) state_nx = ST_RWK;
      ST_WTMP: if (!sleep_nx) state_nx = ST_ACT;
               else if (tmo) state_nx = ST_SLP;
      ST_RWK:  if (link_lock) state_nx = ST_ACT;
               else if (!link_active) state_nx = ST_SLP;
      ST_PD:   if (!pd) state_nx = ST_REL;
      ST_REL:  state_nx = ST_LAT;
      default: state_nx = ST_ACT;
    endcase
    if (pd) state_nx = ST_PD;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_PD;
      sleep_q <= 1'b0;
      cnt     <= '0;
      strap_q <= '0;
    end else begin
      state   <= state_nx;
      sleep_q <= sleep_nx;
      if (state_nx != state || !(state inside {ST_ARM, ST_WTMP})) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (state == ST_LAT) strap_q <= strap_in;
    end

  assign sleep_bit   = sleep_q;
  assign pwr_state   = state;
  assign core_pwr_en = !(state inside {ST_SLP, ST_PD});
  assign out_hiz     = (state == ST_PD);
  assign reg_rst     = (state == ST_PD);
  assign strap_lat   = (state == ST_LAT);
  assign wake_rdy    = (state == ST_WTMP) && (cnt >= CW'(T_WAKE));

  // R2
  arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && sleep_wr && sleep_wdata && !pd) |=> (pwr_state == 3'd1 && sleep_bit));
  // R3
  sleep_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && tmo && sleep_bit && !sleep_wr && !pd) |=> (pwr_state == 3'd2));
  // R4
  local_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && cc_cmd && !pd) |=> (pwr_state == 3'd3 && sleep_bit && core_pwr_en));
  // R5
  wake_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WTMP && sleep_wr && !sleep_wdata && !pd) |=> (pwr_state == 3'd0 && !sleep_bit));
  // R6
  remote_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RWK && link_lock && !pd) |=> (pwr_state == 3'd0 && !sleep_bit));
  // R7
  sleep_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && !cc_cmd && !link_active && !pd) |=> ($stable(sleep_bit) && pwr_state == 3'd2));
  // R8
  pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (pwr_state == 3'd5 && !sleep_bit));
  // R9
  strap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_lat) |-> ($past(reg_rst, 2) && !$past(reg_rst)));

endmodule

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;
  localparam int CPM    = 4;
  localparam int T_SLP  = 8 * CPM;
  localparam int T_WAKE = 5 * CPM;

  logic clk = 1'b0, rst_n = 1'b0, pwdn_n = 1'b1;
  logic sleep_wr = 1'b0, sleep_wdata = 1'b0, cc_cmd = 1'b0;
  logic link_active = 1'b1, link_lock = 1'b0;
  logic [7:0] strap_in = 8'hA5;
  logic sleep_bit, core_pwr_en, out_hiz, reg_rst, strap_lat, wake_rdy;
  logic [7:0] strap_q;
  logic [2:0] pwr_state;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  link_pwr_ctrl #(.CYC_PER_MS(CPM), .SLEEP_MS(8), .WAKE_MS(5), .STRAP_W(8)) u_link_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .sleep_wr(sleep_wr), .sleep_wdata(sleep_wdata),
    .cc_cmd(cc_cmd), .link_active(link_active), .link_lock(link_lock), .strap_in(strap_in),
    .sleep_bit(sleep_bit), .core_pwr_en(core_pwr_en), .out_hiz(out_hiz), .reg_rst(reg_rst),
    .strap_lat(strap_lat), .strap_q(strap_q), .wake_rdy(wake_rdy), .pwr_state(pwr_state));

  always #5 clk = ~clk;

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_sleep();
    link_active = 1'b0; sleep_wr = 1'b1; sleep_wdata = 1'b1;
    tick();
    sleep_wr = 1'b0;
    tick();
    chk("R3 go_sleep state", pwr_state, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset state", pwr_state, 5);
    chk("R1 reset hiz", out_hiz, 1);
    chk("R1 reset reg_rst", reg_rst, 1);
    chk("R1 reset core", core_pwr_en, 0);
    chk("R1 reset sleep", sleep_bit, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R9 release state", pwr_state, 6);
    chk("R9 release reg_rst", reg_rst, 0);
    chk("R9 release strobe", strap_lat, 0);
    tick();
    chk("R9 strobe", strap_lat, 1);
    tick();
    chk("R10 active code", pwr_state, 0);
    chk("R1 strap value", strap_q, 8'hA5);
    chk("R9 strobe width", strap_lat, 0);

    // R2 cancel while armed
    sleep_wr = 1'b1; sleep_wdata = 1'b1; tick();
    chk("R2 armed", pwr_state, 1);
    sleep_wdata = 1'b0; tick(); sleep_wr = 1'b0;
    chk("R2 cancel state", pwr_state, 0);
    chk("R2 cancel bit", sleep_bit, 0);

    // R3 sweep of link drop across the armed window, remote wake to return
    for (int j = 0; j <= T_SLP + 8; j++) begin
      int n;
      int ex;
      link_active = 1'b1;
      sleep_wr = 1'b1; sleep_wdata = 1'b1; tick(); sleep_wr = 1'b0;
      chk("R2 arm state", pwr_state, 1);
      chk("R2 arm bit", sleep_bit, 1);
      n = 0;
      while (pwr_state == 3'd1 && n < 60) begin
        if (n == j) link_active = 1'b0;
        tick(); n++;
      end
      ex = (j + 1 < T_SLP) ? j + 1 : T_SLP;
      chk("R3 entry cycle", n, ex);
      chk("R3 asleep", pwr_state, 2);
      chk("R3 core off", core_pwr_en, 0);
      link_active = 1'b1; tick();
      chk("R6 remote wake", pwr_state, 4);
      chk("R6 core on", core_pwr_en, 1);
      link_lock = 1'b1; tick(); link_lock = 1'b0;
      chk("R6 lock active", pwr_state, 0);
      chk("R6 bit cleared", sleep_bit, 0);
    end

    // R7 write in sleep ignored; R6 remote wake aborted
    go_sleep();
    sleep_wr = 1'b1; sleep_wdata = 1'b0; tick(); sleep_wr = 1'b0;
    chk("R7 bit kept", sleep_bit, 1);
    chk("R7 state kept", pwr_state, 2);
    link_active = 1'b1; tick();
    chk("R6 rwake", pwr_state, 4);
    link_active = 1'b0; tick();
    chk("R6 back to sleep", pwr_state, 2);

    // R4/R5 sweep of confirming write across the temporary wake window
    for (int w = 0; w <= T_SLP + 2; w++) begin
      int n;
      cc_cmd = 1'b1; tick(); cc_cmd = 1'b0;
      chk("R4 temp wake", pwr_state, 3);
      chk("R4 core on", core_pwr_en, 1);
      chk("R4 bit held", sleep_bit, 1);
      n = 0;
      while (pwr_state == 3'd3 && n < 60) begin
        chk("R4 wake_rdy", wake_rdy, (n >= T_WAKE) ? 1 : 0);
        if (n == w) begin sleep_wr = 1'b1; sleep_wdata = 1'b0; end
        tick(); sleep_wr = 1'b0; n++;
      end
      if (w < T_SLP) begin
        chk("R5 confirm cycle", n, w + 1);
        chk("R5 confirmed state", pwr_state, 0);
        chk("R5 confirmed bit", sleep_bit, 0);
        go_sleep();
      end else begin
        chk("R5 timeout cycle", n, T_SLP);
        chk("R5 resleep state", pwr_state, 2);
        chk("R5 resleep bit", sleep_bit, 1);
      end
    end

    // R8/R9 power-down from sleep
    pwdn_n = 1'b0; tick(2);
    chk("R8 sync delay", pwr_state, 2);
    tick();
    chk("R8 pd state", pwr_state, 5);
    chk("R8 hiz", out_hiz, 1);
    chk("R8 reg_rst", reg_rst, 1);
    chk("R8 core off", core_pwr_en, 0);
    chk("R8 bit reset", sleep_bit, 0);
    sleep_wr = 1'b1; sleep_wdata = 1'b1; cc_cmd = 1'b1; link_active = 1'b1;
    tick(); sleep_wr = 1'b0; cc_cmd = 1'b0;
    chk("R8 write ignored", sleep_bit, 0);
    chk("R8 held", pwr_state, 5);
    strap_in = 8'h3C; pwdn_n = 1'b1; tick(2);
    chk("R9 sync delay", pwr_state, 5);
    tick();
    chk("R9 rel state", pwr_state, 6);
    chk("R9 rel reg_rst", reg_rst, 0);
    tick();
    chk("R9 strobe", strap_lat, 1);
    chk("R10 latch code", pwr_state, 7);
    tick();
    chk("R9 active", pwr_state, 0);
    chk("R9 strap", strap_q, 8'h3C);
    chk("R9 hiz off", out_hiz, 0);

    // R8 power-down from armed
    sleep_wr = 1'b1; sleep_wdata = 1'b1; tick(); sleep_wr = 1'b0;
    chk("R2 armed again", pwr_state, 1);
    pwdn_n = 1'b0; tick(3);
    chk("R8 pd from armed", pwr_state, 5);
    chk("R8 bit cleared", sleep_bit, 0);
    pwdn_n = 1'b1; tick(5);
    chk("R9 back active", pwr_state, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule